// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external bus controller read and write a small register file on the chip. It watches the open-drain SCL and SDA lines through a two-flop synchroniser. It detects START, repeated START and STOP, and shifts in bytes most significant bit first. It answers only to its own 7-bit device address, which is set by a parameter.

After the address with a write direction, the next byte selects the register. Its bit 7 switches on stepping through successive registers, and bits 6:0 give the first register. Each further data byte is written through a synchronous register port. A read sets the register with a write phase, then sends a repeated START with the read direction. The target then returns register contents for as long as the controller acknowledges.

The register port is a request/ready handshake. While a request waits for `reg_ready_i`, the target holds SCL low to stall the controller. Read data arrives on `reg_rdata_i` in the cycle after the read request is accepted.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `reg_we_o` and `reg_re_o` are all 0, so both bus lines are released and no register access is requested.
- R2: A byte received after START is taken MSB first. Bits 7:1 are the device address and bit 0 is the direction (0 = write, 1 = read). When bits 7:1 equal `DEV_ADDR`, the target pulls SDA low during the ninth (acknowledge) clock.
- R3: When the address does not match, the target leaves SDA released for the address acknowledge and all later clocks, and requests no register access until the next START.
- R4: In a write transaction the first byte after the address is the sub-address. The target acknowledges it and each following data byte, and writes each complete data byte to the selected register through `reg_we_o`/`reg_addr_o`/`reg_wdata_o`.
- R5: When sub-address bit 7 is 1, each register access advances the register index by one, starting at sub-address bits 6:0. The index wraps from 127 to 0.
- R6: When sub-address bit 7 is 0, every data byte of the transaction, written or read, uses the register given by bits 6:0.
- R7: After a repeated START with the read direction, the target returns the contents of the selected register MSB first, one byte per 8 clocks. It sends another byte after each controller acknowledge and releases SDA for good after a controller non-acknowledge.
- R8: While a register request is pending and `reg_ready_i` is 0, the target holds SCL low. `reg_we_o`, `reg_re_o`, `reg_addr_o` and `reg_wdata_o` stay stable until the request is accepted.
- R9: A STOP or START that arrives inside a byte discards the partial byte without a register write. A START always restarts the address phase and keeps the register index set by the last sub-address.
- R10: The target changes `sda_oe_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | 7 | Register index of the pending access |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Write request, held until accepted |
| reg_re_o | output | 1 | Read request, held until accepted |
| reg_ready_i | input | 1 | Register file accepts the request this cycle |
| reg_rdata_i | input | 8 | Read data, valid one cycle after read acceptance |

## Verification
The acknowledge drive for a data byte and the clock stretch for its register write start in the same SCL low phase. The index step for a read can likewise coincide with the controller's acknowledge of the previous byte. The bench provokes both by toggling `reg_ready_i` at random during every transfer, and by holding it low for a long stretch in one directed write. It then judges the acknowledge bits the controller model sees, the time SCL is held low, the register contents, and the read bytes against a bench model of the register file. A bench monitor also counts any change of `sda_oe_o` while the SCL line is high.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_AW = BYTE_W - 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RFETCH,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s_o    = scl_q[STAGES-1];
  assign sda_s_o    = sda_q[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_d;
  assign scl_fall_o = ~scl_s_o & scl_d;
  // SDA edge with SCL high in both samples
  assign start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;
endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              load_ptr_i,
  input  logic [REG_AW-1:0] ptr_val_i,
  input  logic              auto_val_i,
  input  logic              reg_ready_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic              rdata_vld_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              hold_scl_o
);
  logic [REG_AW-1:0] ptr_q;
  logic              auto_q, cap_q, cap_d_q;
  logic              accept;

  assign accept = (reg_we_o | reg_re_o) & reg_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      auto_q      <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
      reg_wdata_o <= '0;
      cap_q       <= 1'b0;
      cap_d_q     <= 1'b0;
    end else begin
      cap_q   <= reg_re_o & reg_ready_i;
      cap_d_q <= cap_q;
      if (load_ptr_i) begin
        ptr_q  <= ptr_val_i;
        auto_q <= auto_val_i;
      end else if (accept && auto_q) begin
        ptr_q <= ptr_q + 1'b1;
      end
      if (accept) begin
        reg_we_o <= 1'b0;
        reg_re_o <= 1'b0;
      end
      if (wr_req_i) begin
        reg_we_o    <= 1'b1;
        reg_wdata_o <= wdata_i;
      end
      if (rd_req_i) reg_re_o <= 1'b1;
    end
  end

  assign reg_addr_o  = ptr_q;
  assign rdata_vld_o = cap_q;
  assign rdata_o     = reg_rdata_i;
  // keep SCL low one cycle past capture so SDA settles first
  assign hold_scl_o  = reg_we_o | reg_re_o | cap_q | cap_d_q;

  p_req_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_we_o || reg_re_o) && !reg_ready_i) |=>
      ($stable(reg_we_o) && $stable(reg_re_o) && $stable(reg_addr_o) && $stable(reg_wdata_o)));

  p_auto_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && auto_q && !load_ptr_i) |=> (reg_addr_o == $past(reg_addr_o) + 1'b1));

  p_fixed_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !auto_q && !load_ptr_i) |=> $stable(reg_addr_o));

  p_one_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rdata_vld_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              wr_req_o,
  output logic              rd_req_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              load_ptr_o,
  output logic [REG_AW-1:0] ptr_val_o,
  output logic              auto_val_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      rw_q       <= 1'b0;
      nack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_req_o   <= 1'b0;
      rd_req_o   <= 1'b0;
      load_ptr_o <= 1'b0;
    end else begin
      wr_req_o   <= 1'b0;
      rd_req_o   <= 1'b0;
      load_ptr_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise_i && cnt_q != FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= sh_q[0];
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_SUB) begin
                sda_oe_o   <= 1'b1;
                load_ptr_o <= 1'b1;
                state_q    <= ST_SUB_ACK;
              end else begin
                sda_oe_o <= 1'b1;
                wr_req_o <= 1'b1;
                state_q  <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            if (rw_q) begin
              rd_req_o <= 1'b1;
              state_q  <= ST_RFETCH;
            end else begin
              state_q <= ST_SUB;
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_WDATA;
          end
          ST_RFETCH: if (rdata_vld_i) begin
            sh_q     <= rdata_i;
            sda_oe_o <= ~rdata_i[BYTE_W-1];
            cnt_q    <= '0;
            state_q  <= ST_RDATA;
          end
          ST_RDATA: begin
            if (scl_rise_i) cnt_q <= cnt_q + 1'b1;
            else if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                sda_oe_o <= 1'b0;
                cnt_q    <= '0;
                state_q  <= ST_RACK;
              end else begin
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) nack_q <= sda_s_i;
            else if (scl_fall_i) begin
              if (!nack_q) begin
                rd_req_o <= 1'b1;
                state_q  <= ST_RFETCH;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wdata_o    = sh_q;
  assign ptr_val_o  = sh_q[REG_AW-1:0];
  assign auto_val_o = sh_q[BYTE_W-1];

  p_sda_rise_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s_i);

  p_sda_fall_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_s_i);

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!sda_oe_o && !wr_req_o && !rd_req_o));

  p_start_restarts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR && cnt_q == '0 && !wr_req_o));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h1D,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  output logic              scl_oe_o,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic              reg_ready_i,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_req, rd_req, load_ptr, auto_val, rdata_vld;
  logic [BYTE_W-1:0] wdata, rdata;
  logic [REG_AW-1:0] ptr_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
    .rdata_vld_i(rdata_vld), .rdata_i(rdata),
    .sda_oe_o, .wr_req_o(wr_req), .rd_req_o(rd_req), .wdata_o(wdata),
    .load_ptr_o(load_ptr), .ptr_val_o(ptr_val), .auto_val_o(auto_val)
  );

  i2c_reg_port u_port (
    .clk_i, .rst_ni,
    .wr_req_i(wr_req), .rd_req_i(rd_req), .wdata_i(wdata),
    .load_ptr_i(load_ptr), .ptr_val_i(ptr_val), .auto_val_i(auto_val),
    .reg_ready_i, .reg_rdata_i,
    .reg_addr_o, .reg_wdata_o, .reg_we_o, .reg_re_o,
    .rdata_vld_o(rdata_vld), .rdata_o(rdata), .hold_scl_o(scl_oe_o)
  );

  p_stretch_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> !scl_s);
endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [6:0] DEV = 7'h1D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_scl_lo = 1'b0, c_sda_lo = 1'b0;
  logic scl_oe, sda_oe, we, re, rdy = 1'b1;
  logic [6:0] addr;
  logic [7:0] wdata, rdata = 8'h00;
  logic scl_line, sda_line;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic hold_rdy = 1'b0, rand_rdy = 1'b0;
  int n_chk = 0, n_fail = 0, stretch_cyc = 0, sda_viol = 0, oe_cnt = 0;
  logic sda_oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_line = ~(c_scl_lo | scl_oe);
  assign sda_line = ~(c_sda_lo | sda_oe);

  i2c_reg_target #(.DEV_ADDR(DEV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .scl_oe_o(scl_oe),
    .sda_i(sda_line), .sda_oe_o(sda_oe), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_ready_i(rdy), .reg_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we && rdy) mem[addr] <= wdata;
    if (re && rdy) rdata <= mem[addr];
  end

  always @(negedge clk) begin
    rdy <= hold_rdy ? 1'b0 : (rand_rdy ? ($urandom % 4 != 0) : 1'b1);
    if (rst_n && sda_oe != sda_oe_prev && scl_line) sda_viol++;
    if (sda_oe) oe_cnt++;
    sda_oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 128; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_pulse(output bit smp);
    c_scl_lo = 1'b0;
    @(negedge clk);
    while (!scl_line) begin stretch_cyc++; @(negedge clk); end
    wq(Q); smp = sda_line; wq(Q);
    c_scl_lo = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input bit b, output bit smp);
    c_sda_lo = ~b; wq(Q); scl_pulse(smp);
  endtask

  task automatic bus_start();
    bit s;
    c_sda_lo = 1'b0; wq(Q);
    c_scl_lo = 1'b0; @(negedge clk);
    while (!scl_line) @(negedge clk);
    wq(Q); c_sda_lo = 1'b1; wq(Q); c_scl_lo = 1'b1; wq(Q);
    s = 0;
  endtask

  task automatic bus_stop();
    c_sda_lo = 1'b1; wq(Q);
    c_scl_lo = 1'b0; @(negedge clk);
    while (!scl_line) @(negedge clk);
    wq(Q); c_sda_lo = 1'b0; wq(3*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit ack);
    bit s;
    c_sda_lo = 1'b0; d = '0;
    for (int i = 0; i < 8; i++) begin wq(Q); scl_pulse(s); d = {d[6:0], s}; end
    put_bit(~ack, s);
  endtask

  // write transaction; returns number of acks seen
  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] sub,
                        input logic [7:0] d [8], input int n, output int acks);
    bit a;
    logic [6:0] p = sub[6:0];
    acks = 0;
    bus_start();
    wr_byte({dev, 1'b0}, a); acks += a;
    wr_byte(sub, a); acks += a;
    for (int i = 0; i < n; i++) begin wr_byte(d[i], a); acks += a; end
    bus_stop();
    if (dev == DEV)
      for (int i = 0; i < n; i++) begin exp_mem[p] = d[i]; if (sub[7]) p = p + 1'b1; end
  endtask

  task automatic rd_txn(input logic [7:0] sub, input int n, input string req);
    bit a;
    int acks = 0;
    logic [7:0] got;
    logic [6:0] p = sub[6:0];
    bus_start();
    wr_byte({DEV, 1'b0}, a); acks += a;
    wr_byte(sub, a); acks += a;
    bus_start();
    wr_byte({DEV, 1'b1}, a); acks += a;
    chk(acks == 3, {req, " R2 acks"}, acks, 3);
    for (int i = 0; i < n; i++) begin
      rd_byte(got, i != n - 1);
      chk(got === exp_mem[p], req, got, exp_mem[p]);
      if (sub[7]) p = p + 1'b1;
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
  endtask

  initial begin
    logic [7:0] d [8];
    int acks;
    bit s, a;
    logic [7:0] got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) begin mem[i] = 8'($urandom); exp_mem[i] = mem[i]; end
    wq(5); rst_n = 1'b1; wq(5);
    chk({scl_oe, sda_oe, we, re} == 4'b0, "R1 reset", {scl_oe, sda_oe, we, re}, 0);

    // R2 R4 R5: auto-increment write
    for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
    wr_txn(DEV, 8'h90, d, 4, acks);
    chk(acks == 6, "R2 R4 write acks", acks, 6);
    chk_mem("R5 auto write");

    // R3: foreign address
    oe_cnt = 0;
    wr_txn(7'h2A, 8'h90, d, 3, acks);
    chk(acks == 0, "R3 no ack", acks, 0);
    chk(oe_cnt == 0, "R3 sda untouched", oe_cnt, 0);
    chk_mem("R3 no write");

    // R6: fixed register write
    for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
    wr_txn(DEV, 8'h22, d, 3, acks);
    chk(mem[7'h22] === d[2], "R6 last byte wins", mem[7'h22], d[2]);
    chk_mem("R6 fixed write");

    rd_txn(8'h90, 5, "R7 auto read");
    rd_txn(8'h22, 3, "R6 fixed read");

    // R5 wrap
    for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
    wr_txn(DEV, 8'hFE, d, 4, acks);
    chk(mem[0] === d[2] && mem[1] === d[3], "R5 wrap write", {mem[0], mem[1]}, {d[2], d[3]});
    rd_txn(8'hFE, 4, "R5 wrap read");

    // R8: long stall
    stretch_cyc = 0; hold_rdy = 1'b1;
    fork
      begin @(posedge we); wq(300); hold_rdy = 1'b0; end
      begin d[0] = 8'hA5; wr_txn(DEV, 8'h40, d, 1, acks); end
    join
    chk(stretch_cyc >= 250, "R8 scl held", stretch_cyc, 250);
    chk(mem[7'h40] === 8'hA5, "R8 stalled write lands", mem[7'h40], 8'hA5);

    // R9: STOP inside a data byte
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h85, a);
    for (int i = 0; i < 5; i++) put_bit(1'b0, s);
    bus_stop();
    chk_mem("R9 stop drops partial byte");

    // R9: repeated START inside a data byte
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h30, a);
    for (int i = 0; i < 3; i++) put_bit(1'b1, s);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    chk(a == 1'b1, "R9 restart address ack", a, 1);
    rd_byte(got, 1'b0);
    bus_stop();
    chk(got === exp_mem[7'h30], "R9 index kept", got, exp_mem[7'h30]);
    chk_mem("R9 no write on restart");

    // random mix with random ready
    rand_rdy = 1'b1;
    for (int t = 0; t < 16; t++) begin
      logic [7:0] sub = 8'($urandom);
      int n = 1 + int'($urandom % 5);
      if ($urandom % 2 == 0) begin
        for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
        wr_txn(DEV, sub, d, n, acks);
        chk(acks == n + 2, "R4 random write acks", acks, n + 2);
      end else begin
        rd_txn(sub, n, "R7 random read");
      end
    end
    chk_mem("R4 random final");
    chk(sda_viol == 0, "R10 sda vs scl high", sda_viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule